// File: doc/BRIEF.md
# Write-Hot Line Migration State Controller

This block sits beside one set of a hybrid cache whose ways are split into a fast-write region and a slow-write region. For every way of the slow region it holds a 2-bit region tag. It follows the life of each line from the allocation on an L1 miss, through the writebacks that L1 caches return, to the point where the line has shown itself write-hot. It then pulls the line into the fast region before the data is written.

An allocation on a miss only marks the way as holding a line without data; nothing is written to the slow array. The first writeback to such a line writes the slow array and marks the line as a candidate. A second writeback to a candidate is held. The block asks the swap datapath to exchange the line with a fast-region victim. After a fixed number of cycles it releases the held writeback, which then lands in the fast region. Lines that have already moved keep their tag, and their writebacks go straight to the fast region. Invalidation returns a way to the unused tag. The data arrays and the swap buffer lie outside this block.

Top module: `mgs_ctrl`

## Requirements
- R1: After reset every way carries the unused tag, `wb_ready` is high and every pulse output and `wb_stall` are low. A writeback to any way right after reset produces no write and no migration.
- R2: A fill marks its way as dataless and produces no write pulse. A later writeback to that way is then handled as a first writeback.
- R3: A writeback accepted to a dataless way raises `wb_to_slow` for one cycle, in the cycle after acceptance, and turns the way into a candidate.
- R4: A writeback accepted to a candidate way raises `mig_req` for one cycle, in the cycle after acceptance, with `mig_src_way` equal to that way. `wb_stall` rises in the same cycle.
- R5: `wb_stall` stays high for exactly MIG_CYCLES cycles. In the following cycle `wb_resume` and `wb_to_fast` pulse together, and the way becomes migrated.
- R6: A writeback to a migrated way raises `wb_to_fast` alone, with no stall, and leaves the tag migrated, however many times it repeats.
- R7: An invalidate returns its way to the unused tag. A writeback to an unused way is accepted and has no effect: no pulse, no stall.
- R8: While `wb_stall` is high, `wb_ready` is low and a presented writeback is not accepted. A writeback held through the stall is accepted in the cycle `wb_resume` is high.
- R9: When a fill or an invalidate names the same way as an accepted writeback in the same cycle, the writeback's output follows the old tag, but the way ends in the fill's or invalidate's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | Miss allocation into a slow-region way |
| fill_way | input | WAY_W | Way being allocated |
| inval_vld | input | 1 | Invalidate or evict a slow-region way |
| inval_way | input | WAY_W | Way being invalidated |
| wb_vld | input | 1 | L1 writeback presented |
| wb_way | input | WAY_W | Way targeted by the writeback |
| wb_ready | output | 1 | Writeback accepted when high together with wb_vld |
| wb_to_slow | output | 1 | Pulse: write the writeback data into the slow array |
| wb_to_fast | output | 1 | Pulse: write the writeback data into the fast array |
| wb_stall | output | 1 | A writeback is paused during a migration |
| mig_req | output | 1 | Pulse: start a swap of the source way with a fast victim |
| mig_src_way | output | WAY_W | Slow-region way being migrated |
| wb_resume | output | 1 | Pulse: the paused writeback continues |

## Verification
Two pairs of events can share a cycle. The first is the release of a paused writeback and the acceptance of the next writeback. The bench provokes it by holding a second writeback valid through the whole stall, and it judges the result by the first-writeback pulse one cycle after `wb_resume`. The second is a writeback to a way that a fill or an invalidate names in the same cycle. The bench judges it by the pulse of that writeback and by the outcome of one more writeback to the same way.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
    typedef enum logic [1:0] {
        RG_UNUSED   = 2'b00,
        RG_DATALESS = 2'b01,
        RG_CAND     = 2'b10,
        RG_MIGRATED = 2'b11
    } region_e;
endpackage

// File: rtl/mgs_region_table.sv
module mgs_region_table
    import mgs_pkg::*;
#(
    parameter  int WAYS  = 12,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             inval_vld,
    input  logic [WAY_W-1:0] inval_way,
    input  logic             set_vld,
    input  logic [WAY_W-1:0] set_way,
    input  region_e          set_val,
    input  logic [WAY_W-1:0] rd_way,
    output region_e          rd_val
);
    region_e tag_d [WAYS];
    region_e tag_q [WAYS];

    // Priority, lowest first: writeback/migration update, fill, invalidate.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            tag_d[w] = tag_q[w];
            if (set_vld && (int'(set_way) == w))     tag_d[w] = set_val;
            if (fill_vld && (int'(fill_way) == w))   tag_d[w] = RG_DATALESS;
            if (inval_vld && (int'(inval_way) == w)) tag_d[w] = RG_UNUSED;
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (!rst_n) tag_q[w] <= RG_UNUSED;
            else        tag_q[w] <= tag_d[w];
        end
    end

    assign rd_val = (int'(rd_way) < WAYS) ? tag_q[rd_way] : RG_UNUSED;
endmodule

// File: rtl/mgs_mover.sv
module mgs_mover #(
    parameter  int WAYS       = 12,
    parameter  int MIG_CYCLES = 4,
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int CNT_W      = $clog2(MIG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WAY_W-1:0] start_way,
    output logic             busy,
    output logic             mig_req,
    output logic [WAY_W-1:0] mig_way,
    output logic             finish
);
    typedef struct packed {
        logic             busy;
        logic             req;
        logic [CNT_W-1:0] cnt;
        logic [WAY_W-1:0] way;
    } mover_t;

    mover_t mv_d, mv_q;

    always_comb begin
        mv_d     = mv_q;
        mv_d.req = 1'b0;
        if (mv_q.busy) begin
            if (mv_q.cnt == '0) mv_d.busy = 1'b0;
            else                mv_d.cnt  = mv_q.cnt - 1'b1;
        end else if (start) begin
            mv_d.busy = 1'b1;
            mv_d.req  = 1'b1;
            mv_d.cnt  = CNT_W'(MIG_CYCLES - 1);
            mv_d.way  = start_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign busy    = mv_q.busy;
    assign mig_req = mv_q.req;
    assign mig_way = mv_q.way;
    assign finish  = mv_q.busy && (mv_q.cnt == '0);
endmodule

// File: rtl/mgs_ctrl.sv
module mgs_ctrl
    import mgs_pkg::*;
#(
    parameter  int SLOW_WAYS  = 12,
    parameter  int MIG_CYCLES = 4,
    localparam int WAY_W      = (SLOW_WAYS > 1) ? $clog2(SLOW_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_vld,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             inval_vld,
    input  logic [WAY_W-1:0] inval_way,
    input  logic             wb_vld,
    input  logic [WAY_W-1:0] wb_way,
    output logic             wb_ready,
    output logic             wb_to_slow,
    output logic             wb_to_fast,
    output logic             wb_stall,
    output logic             mig_req,
    output logic [WAY_W-1:0] mig_src_way,
    output logic             wb_resume
);
    typedef struct packed {
        logic to_slow;
        logic to_fast;
        logic resume;
    } pulse_t;

    pulse_t           pl_d, pl_q;
    region_e          cur_tag;
    region_e          set_val;
    logic             set_vld;
    logic [WAY_W-1:0] set_way;
    logic             accept, mv_busy, mv_finish, mv_start;
    logic [WAY_W-1:0] mv_way;

    assign wb_ready = !mv_busy;
    assign accept   = wb_vld && wb_ready;
    assign mv_start = accept && (cur_tag == RG_CAND);

    always_comb begin
        set_vld = 1'b0;
        set_way = wb_way;
        set_val = RG_CAND;
        if (mv_finish) begin
            set_vld = 1'b1;
            set_way = mv_way;
            set_val = RG_MIGRATED;
        end else if (accept && (cur_tag == RG_DATALESS)) begin
            set_vld = 1'b1;
        end
        pl_d.to_slow = accept && (cur_tag == RG_DATALESS);
        pl_d.to_fast = (accept && (cur_tag == RG_MIGRATED)) || mv_finish;
        pl_d.resume  = mv_finish;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pl_q <= '0;
        else        pl_q <= pl_d;
    end

    mgs_region_table #(.WAYS(SLOW_WAYS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_vld  (fill_vld),
        .fill_way  (fill_way),
        .inval_vld (inval_vld),
        .inval_way (inval_way),
        .set_vld   (set_vld),
        .set_way   (set_way),
        .set_val   (set_val),
        .rd_way    (wb_way),
        .rd_val    (cur_tag)
    );

    mgs_mover #(.WAYS(SLOW_WAYS), .MIG_CYCLES(MIG_CYCLES)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mv_start),
        .start_way (wb_way),
        .busy      (mv_busy),
        .mig_req   (mig_req),
        .mig_way   (mv_way),
        .finish    (mv_finish)
    );

    assign wb_to_slow  = pl_q.to_slow;
    assign wb_to_fast  = pl_q.to_fast;
    assign wb_resume   = pl_q.resume;
    assign wb_stall    = mv_busy;
    assign mig_src_way = mv_way;
endmodule

// File: rtl/mgs_ctrl_chk.sv
module mgs_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wb_vld,
    input logic wb_ready,
    input logic wb_to_slow,
    input logic wb_to_fast,
    input logic wb_stall,
    input logic mig_req,
    input logic wb_resume
);
    // R4
    mig_with_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |-> wb_stall);
    // R4
    stall_starts_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_stall) |-> mig_req);
    // R4
    req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |-> $past(wb_vld && wb_ready));
    // R5
    stall_ends_in_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_stall) |-> wb_resume);
    // R5
    resume_goes_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_resume |-> (wb_to_fast && !wb_to_slow && !wb_stall));
    // R3
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_to_slow, wb_to_fast, mig_req}));
    // R8
    no_write_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stall |-> !wb_to_slow);
endmodule

bind mgs_ctrl mgs_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_vld     (wb_vld),
    .wb_ready   (wb_ready),
    .wb_to_slow (wb_to_slow),
    .wb_to_fast (wb_to_fast),
    .wb_stall   (wb_stall),
    .mig_req    (mig_req),
    .wb_resume  (wb_resume)
);

// File: tb/mgs_ctrl_tb.sv
module mgs_ctrl_tb;
    localparam int WAYS = 12;
    localparam int MIG  = 4;
    localparam int WW   = $clog2(WAYS);

    // vector word: {op[1:0], way[3:0], expect[1:0]}
    // op: 0 fill, 1 inval, 2 writeback; expect: 0 none, 1 slow, 2 fast, 3 migrate
    localparam int NV = 16;
    localparam logic [7:0] VEC [NV] = '{
        {2'd2, 4'd3,  2'd0}, {2'd0, 4'd3,  2'd0}, {2'd2, 4'd3,  2'd1}, {2'd2, 4'd3,  2'd3},
        {2'd2, 4'd3,  2'd2}, {2'd2, 4'd3,  2'd2}, {2'd0, 4'd5,  2'd0}, {2'd0, 4'd11, 2'd0},
        {2'd2, 4'd11, 2'd1}, {2'd2, 4'd5,  2'd1}, {2'd2, 4'd11, 2'd3}, {2'd1, 4'd3,  2'd0},
        {2'd2, 4'd3,  2'd0}, {2'd0, 4'd3,  2'd0}, {2'd2, 4'd3,  2'd1}, {2'd2, 4'd0,  2'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic fill_vld = 0, inval_vld = 0, wb_vld = 0;
    logic [WW-1:0] fill_way = '0, inval_way = '0, wb_way = '0;
    logic wb_ready, wb_to_slow, wb_to_fast, wb_stall, mig_req, wb_resume;
    logic [WW-1:0] mig_src_way;
    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    mgs_ctrl #(.SLOW_WAYS(WAYS), .MIG_CYCLES(MIG)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int outcome();
        return mig_req ? 3 : wb_to_fast ? 2 : wb_to_slow ? 1 : 0;
    endfunction

    task automatic wait_migration(input string req);
        for (int j = 2; j <= MIG; j++) begin
            @(negedge clk);
            chk(wb_stall && !wb_ready && outcome() == 0, req, {wb_stall, wb_ready}, 2);
        end
        @(negedge clk);
        chk(wb_resume && wb_to_fast && wb_ready && !wb_stall, "R5 resume", {wb_resume, wb_to_fast}, 3);
    endtask

    task automatic apply(input logic [1:0] op, input logic [WW-1:0] way, input int exp_v);
        @(negedge clk);
        fill_vld = (op == 0); inval_vld = (op == 1); wb_vld = (op == 2);
        fill_way = way; inval_way = way; wb_way = way;
        @(negedge clk);
        fill_vld = 0; inval_vld = 0; wb_vld = 0;
        chk(outcome() == exp_v, exp_v == 0 ? "R7/R2 none" : exp_v == 1 ? "R3 slow" :
            exp_v == 2 ? "R6 fast" : "R4 migrate", outcome(), exp_v);
        if (exp_v == 3) begin
            chk(wb_stall && mig_src_way == way, "R4 source", int'(mig_src_way), int'(way));
            wait_migration("R5 stall");
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(wb_ready && !wb_stall && outcome() == 0 && !wb_resume, "R1 reset", outcome(), 0);
        apply(2'd2, 4'd7, 0);   // R1 unused after reset

        for (int i = 0; i < NV; i++)
            apply(VEC[i][7:6], VEC[i][5:2], int'(VEC[i][1:0]));

        // R8: writeback held through a migration is taken at resume
        apply(2'd0, 4'd2, 0);
        apply(2'd2, 4'd2, 1);
        apply(2'd0, 4'd4, 0);
        @(negedge clk);
        wb_vld = 1; wb_way = 4'd2;
        @(negedge clk);
        chk(mig_req && mig_src_way == 4'd2, "R8 start", outcome(), 3);
        wb_way = 4'd4;
        wait_migration("R8 held");
        @(negedge clk);
        wb_vld = 0;
        chk(wb_to_slow && !wb_stall, "R8 accepted after resume", outcome(), 1);

        // R9: fill and writeback on the same way in one cycle
        apply(2'd0, 4'd9, 0);
        @(negedge clk);
        fill_vld = 1; fill_way = 4'd9; wb_vld = 1; wb_way = 4'd9;
        @(negedge clk);
        fill_vld = 0; wb_vld = 0;
        chk(outcome() == 1, "R9 wb uses old tag", outcome(), 1);
        apply(2'd2, 4'd9, 1);   // R9 fill won: still dataless

        // R9: invalidate and writeback on the same way in one cycle
        apply(2'd0, 4'd10, 0);
        @(negedge clk);
        inval_vld = 1; inval_way = 4'd10; wb_vld = 1; wb_way = 4'd10;
        @(negedge clk);
        inval_vld = 0; wb_vld = 0;
        chk(outcome() == 1, "R9 wb with inval", outcome(), 1);
        apply(2'd2, 4'd10, 0);  // R9 invalidate won: unused

        // R6: migrated way 11 stays migrated
        apply(2'd2, 4'd11, 2);
        apply(2'd2, 4'd11, 2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule